// File: doc/BRIEF.md
# Programmable Timing Pulse Generator

This block produces one configurable timing signal for a display panel. It runs on the pixel clock and keeps two counters. A pixel counter restarts on every line-start strobe. A line counter restarts on every frame-start strobe and advances on each line-start strobe. The output is asserted while both counters lie inside a programmed rectangle, given by a pixel start and width and a line start and height.

A three-bit mode word selects among three features:
- An inverted output level.
- A toggle mode. The output flips once for every N line-window entries.
- An early-start mode. The starting line is counted back from the end of the frame, using a frame height that the block measures itself.

The measured height and a flag saying it is valid are also outputs.

Top module: `timing_pulse_gen`

## Requirements
- R1: While rstN is low, pulseOut, frameLines and frameLinesValid are all 0.
- R2: Counter rules:
  - The pixel index becomes 0 on the clock edge that samples lineStart high, and otherwise advances by one per clock.
  - The line index becomes 0 on an edge that samples frameStart high, and otherwise advances by one on each edge that samples lineStart high.
  - With mode = 3'b000, pulseOut is 1 on the edge after a cycle in which the line index is in [cfgLineStart, cfgLineStart+cfgLineLen) and the pixel index is in [cfgPixStart, cfgPixStart+cfgPixLen). It is 0 after any other cycle.
- R3: In normal mode, a pixel width of 0 or a line height of 0 keeps pulseOut at its inactive level for every cycle.
- R4: Mode bit 0 set inverts pulseOut, giving an active-low output. Clear gives an active-high output.
- R5: Mode bit 1 set selects toggle mode.
  - A toggle event is a cycle where the line index is inside the line window and the pixel index equals cfgPixStart.
  - cfgPixLen holds N-1. Every N-th event flips an internal level, which starts at 0 after reset.
  - pulseOut shows that level, XORed with mode bit 0, on the edge after the event.
  - The level and the event count persist across frames.
- R6: Mode bit 2 set selects early start. The line window starts at frameLines - cfgLineStart. The output stays inactive while frameLinesValid is 0, or while cfgLineStart exceeds frameLines.
- R7: Height measurement:
  - On each frameStart edge except the first after reset, frameLines loads the line index plus one, which is the number of lines in the frame that just ended.
  - frameLines holds its value at every other edge.
- R8: frameLinesValid rises on the second frameStart edge after reset and then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStart | input | 1 | Start-of-line strobe |
| frameStart | input | 1 | Start-of-frame strobe |
| cfgPixStart | input | 10 | First active pixel |
| cfgPixLen | input | 11 | Active pixel width; toggle period minus one in toggle mode |
| cfgLineStart | input | 11 | First active line, or offset back from the frame end in early start |
| cfgLineLen | input | 11 | Active line count |
| cfgMode | input | 3 | Bit 0: invert; bit 1: toggle; bit 2: early start |
| pulseOut | output | 1 | Timing output |
| frameLines | output | 12 | Measured lines per frame |
| frameLinesValid | output | 1 | Measurement valid |

## Verification
The strobes reach the counters on the edge that samples them. pulseOut reflects the counters and the mode one edge later, so a strobe affects the output two edges after it is sampled. frameLines and frameLinesValid update on the very edge that samples frameStart.

The bench drives inputs at the falling edge and advances its own counter and toggle model once per cycle from the requirements. It then compares all three outputs at the next falling edge, which keeps every comparison at the cycle each result is due.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  // Strobes from the control path into the output datapath
  typedef struct packed {
    logic winActive;   // counters lie inside the programmed rectangle
    logic tglEvent;    // first pixel of the window on a windowed line
  } tpg_strobe_t;

  // Mode bit positions
  localparam int MODE_INVERT = 0;
  localparam int MODE_TOGGLE = 1;
  localparam int MODE_EARLY  = 2;
  localparam int MODE_W      = 3;

endpackage

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
#(
  parameter int PS_W   = 10,
  parameter int DUR_W  = 11,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic [PS_W-1:0]   pixStart,
  input  logic [DUR_W-1:0]  pixLen,
  input  logic [LINE_W-1:0] lnStart,
  input  logic [LINE_W-1:0] lnLen,
  input  logic              earlyEn,
  output logic [LINE_W:0]   frameLines,
  output logic              heightValid,
  output tpg_strobe_t       st
);

  localparam int PIX_W = DUR_W + 1;
  localparam int FL_W  = LINE_W + 1;
  localparam int CMP_W = LINE_W + 2 > PIX_W + 1 ? LINE_W + 2 : PIX_W + 1;
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);
  localparam logic [FL_W-1:0]   FL_ONE   = FL_W'(1);

  logic [PIX_W-1:0]  pixCnt;
  logic [LINE_W-1:0] lineCnt;
  logic              seenFrame;

  // Running counters and frame height capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt      <= '0;
      lineCnt     <= '0;
      seenFrame   <= 1'b0;
      frameLines  <= '0;
      heightValid <= 1'b0;
    end else begin
      if (lineStart) begin
        pixCnt <= '0;
      end else if (pixCnt != PIX_MAX) begin
        pixCnt <= pixCnt + PIX_ONE;
      end

      if (frameStart) begin
        lineCnt <= '0;
        if (seenFrame) begin
          frameLines  <= FL_W'(lineCnt) + FL_ONE;
          heightValid <= 1'b1;
        end
        seenFrame <= 1'b1;
      end else if (lineStart && lineCnt != LINE_MAX) begin
        lineCnt <= lineCnt + LINE_ONE;
      end
    end
  end

  // Window decode
  logic [CMP_W-1:0] pixC, pixLo, pixHi;
  logic [CMP_W-1:0] lineC, lineLo, lineHi, heightC, offsetC;
  logic             lineOk, lineWin, pixWin;

  always_comb begin
    pixC    = CMP_W'(pixCnt);
    pixLo   = CMP_W'(pixStart);
    pixHi   = pixLo + CMP_W'(pixLen);
    lineC   = CMP_W'(lineCnt);
    heightC = CMP_W'(frameLines);
    offsetC = CMP_W'(lnStart);
    if (earlyEn) begin
      lineOk = heightValid && (offsetC <= heightC);
      lineLo = heightC - offsetC;
    end else begin
      lineOk = 1'b1;
      lineLo = offsetC;
    end
    lineHi  = lineLo + CMP_W'(lnLen);
    lineWin = lineOk && (lineC >= lineLo) && (lineC < lineHi);
    pixWin  = (pixC >= pixLo) && (pixC < pixHi);
    st.winActive = lineWin && pixWin;
    st.tglEvent  = lineWin && (pixC == pixLo);
  end

endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int DUR_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  tpg_strobe_t      st,
  input  logic             invert,
  input  logic             toggleEn,
  input  logic [DUR_W-1:0] period,
  output logic             pulseOut
);

  localparam logic [DUR_W-1:0] EV_ONE = DUR_W'(1);

  logic [DUR_W-1:0] evCnt;
  logic             tglState;
  logic             wrapHit;
  logic             level;

  always_comb begin
    wrapHit = st.tglEvent && (evCnt == period);
    level   = toggleEn ? (tglState ^ wrapHit) : st.winActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evCnt    <= '0;
      tglState <= 1'b0;
      pulseOut <= 1'b0;
    end else begin
      pulseOut <= level ^ invert;
      if (toggleEn && st.tglEvent) begin
        if (wrapHit) begin
          evCnt    <= '0;
          tglState <= ~tglState;
        end else begin
          evCnt <= evCnt + EV_ONE;
        end
      end
    end
  end

endmodule

// File: rtl/timing_pulse_gen.sv
module timing_pulse_gen
  import tpg_pkg::*;
#(
  parameter int PS_W   = 10,
  parameter int DUR_W  = 11,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic              frameStart,
  input  logic [PS_W-1:0]   cfgPixStart,
  input  logic [DUR_W-1:0]  cfgPixLen,
  input  logic [LINE_W-1:0] cfgLineStart,
  input  logic [LINE_W-1:0] cfgLineLen,
  input  logic [2:0]        cfgMode,
  output logic              pulseOut,
  output logic [LINE_W:0]   frameLines,
  output logic              frameLinesValid
);

  tpg_strobe_t strobes;

  tpg_ctrl #(
    .PS_W  (PS_W),
    .DUR_W (DUR_W),
    .LINE_W(LINE_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineStart  (lineStart),
    .frameStart (frameStart),
    .pixStart   (cfgPixStart),
    .pixLen     (cfgPixLen),
    .lnStart    (cfgLineStart),
    .lnLen      (cfgLineLen),
    .earlyEn    (cfgMode[MODE_EARLY]),
    .frameLines (frameLines),
    .heightValid(frameLinesValid),
    .st         (strobes)
  );

  tpg_datapath #(
    .DUR_W(DUR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (strobes),
    .invert  (cfgMode[MODE_INVERT]),
    .toggleEn(cfgMode[MODE_TOGGLE]),
    .period  (cfgPixLen),
    .pulseOut(pulseOut)
  );

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import tpg_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input logic            clk,
  input logic            rstN,
  input logic            frameStart,
  input logic [2:0]      cfgMode,
  input tpg_strobe_t     st,
  input logic            pulseOut,
  input logic [LINE_W:0] frameLines,
  input logic            frameLinesValid
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R2 and R4: normal-mode output follows the decoded window one edge later
  a_r2_window_level: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode[1] |=> pulseOut == ($past(st.winActive) ^ $past(cfgMode[0])));

  // R5: without a toggle event the toggle output holds
  a_r5_toggle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (armed && cfgMode[1] && !st.tglEvent && $stable(cfgMode)) |=> $stable(pulseOut));

  // R6: early start stays inactive until a height is measured
  a_r6_early_gate: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode[2] && !cfgMode[1] && !frameLinesValid) |=> pulseOut == $past(cfgMode[0]));

  // R7: height only changes on a frame strobe
  a_r7_height_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(frameLines));

  // R8: valid rises only on a frame strobe and then sticks
  a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameLinesValid) |-> $past(frameStart));

  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    frameLinesValid |=> frameLinesValid);

endmodule

bind timing_pulse_gen tpg_checker #(.LINE_W(LINE_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .frameStart     (frameStart),
  .cfgMode        (cfgMode),
  .st             (strobes),
  .pulseOut       (pulseOut),
  .frameLines     (frameLines),
  .frameLinesValid(frameLinesValid)
);

// File: tb/sim_timing_pulse_gen.sv
`timescale 1ns/1ps
module sim_timing_pulse_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0;
  logic        frameStart = 1'b0;
  logic [9:0]  cfgPixStart = '0;
  logic [10:0] cfgPixLen = '0;
  logic [10:0] cfgLineStart = '0;
  logic [10:0] cfgLineLen = '0;
  logic [2:0]  cfgMode = '0;
  logic        pulseOut;
  logic [11:0] frameLines;
  logic        frameLinesValid;

  timing_pulse_gen u0 (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .frameStart(frameStart),
    .cfgPixStart(cfgPixStart), .cfgPixLen(cfgPixLen),
    .cfgLineStart(cfgLineStart), .cfgLineLen(cfgLineLen), .cfgMode(cfgMode),
    .pulseOut(pulseOut), .frameLines(frameLines), .frameLinesValid(frameLinesValid)
  );

  always #2.5 clk = ~clk;

  int    errs = 0;
  int    checks = 0;
  string tag = "R2";
  int    mPix, mLine, mFL, mEv;
  bit    mSeen, mValid, mTgl;

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic modelReset();
    mPix = 0; mLine = 0; mFL = 0; mEv = 0;
    mSeen = 0; mValid = 0; mTgl = 0;
  endtask

  // R1: reset values
  task automatic doReset();
    rstN = 1'b0; lineStart = 1'b0; frameStart = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", pulseOut, 0);
    check("R1", frameLines, 0);
    check("R1", frameLinesValid, 0);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic setCfg(int ps, int pd, int ls, int ld, int mode);
    cfgPixStart = 10'(ps); cfgPixLen = 11'(pd);
    cfgLineStart = 11'(ls); cfgLineLen = 11'(ld); cfgMode = 3'(mode);
  endtask

  // One clock: drive, predict from the requirements, compare after the edge
  task automatic step(bit ls, bit fs);
    int lo, ps, pd, ld, offs;
    bit lineOk, lw, pw, ev, lvl;
    int expOut;
    lineStart = ls; frameStart = fs;
    ps = int'(cfgPixStart); pd = int'(cfgPixLen);
    ld = int'(cfgLineLen); offs = int'(cfgLineStart);
    if (cfgMode[2]) begin
      lineOk = mValid && (offs <= mFL);
      lo = mFL - offs;
    end else begin
      lineOk = 1'b1;
      lo = offs;
    end
    lw = lineOk && (mLine >= lo) && (mLine < lo + ld);
    pw = (mPix >= ps) && (mPix < ps + pd);
    ev = lw && (mPix == ps);
    if (cfgMode[1]) begin
      lvl = mTgl;
      if (ev) begin
        if (mEv == pd) begin
          mTgl = !mTgl; mEv = 0; lvl = mTgl;
        end else begin
          mEv = (mEv + 1) % 2048;
        end
      end
    end else begin
      lvl = lw && pw;
    end
    expOut = int'(lvl ^ cfgMode[0]);
    if (fs) begin
      if (mSeen) begin mFL = mLine + 1; mValid = 1'b1; end
      mSeen = 1'b1;
      mLine = 0;
    end else if (ls && mLine < 2047) begin
      mLine++;
    end
    if (ls) mPix = 0;
    else if (mPix < 4095) mPix++;
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(pulseOut), expOut);
    check("R7", int'(frameLines), mFL);
    check("R8", int'(frameLinesValid), int'(mValid));
  endtask

  task automatic frame(int lines, int ppl);
    for (int l = 0; l < lines; l++)
      for (int p = 0; p < ppl; p++)
        step(p == 0, (p == 0) && (l == 0));
  endtask

  initial begin
    int lines, ppl, mode;
    void'($urandom(32'd2024));
    modelReset();
    @(negedge clk);
    doReset();

    tag = "R2"; setCfg(5, 10, 2, 3, 0);  repeat (3) frame(12, 30);
    tag = "R4"; setCfg(7, 6, 1, 4, 1);   repeat (2) frame(12, 30);
    tag = "R3"; setCfg(5, 0, 2, 3, 0);   frame(12, 30);
    setCfg(5, 10, 2, 0, 1);              frame(12, 30);

    tag = "R5"; doReset(); setCfg(4, 0, 1, 6, 2);  repeat (2) frame(12, 30);
    doReset(); setCfg(4, 2, 0, 12, 3);             repeat (2) frame(12, 30);

    tag = "R6"; doReset(); setCfg(3, 8, 4, 2, 4);  repeat (3) frame(12, 30);
    setCfg(3, 8, 20, 2, 4);   frame(12, 30);
    setCfg(3, 8, 12, 3, 5);   frame(12, 30);
    setCfg(2, 1, 5, 3, 6);    frame(12, 30);

    for (int i = 0; i < 10; i++) begin
      doReset();
      lines = 8 + int'($urandom % 8);
      ppl = 20 + int'($urandom % 20);
      mode = int'($urandom % 8);
      setCfg(int'($urandom % ppl), int'($urandom % ppl), int'($urandom % lines),
             1 + int'($urandom % lines), mode);
      tag = (mode[1]) ? "R5" : (mode[2]) ? "R6" : (mode[0]) ? "R4" : "R2";
      repeat (3) frame(lines, ppl);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errs++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule